// File: doc/BRIEF.md
# Size-Typed Integer Execution Unit

This block is a purely combinational 64-bit integer execution unit in which every operation is tagged with a data type. The type has two parts. One is a signedness bit. The other is an operand size of 8, 16, 32 or 64 bits. Together they give eight type combinations.

The unit computes the operation and then reduces the result to the requested size. It writes that reduced value back as a full 64-bit register value. The bits above the size are a true sign extension for signed types and zeros for unsigned types. This matches the way loaded memory values are presented, so compiled code needs no separate extend or shift-pair instructions to clean up a result.

Compares and shifts look only at the low bits of the selected size. Bits above that size in the sources are ignored, so stale upper contents in a register can never leak into a result or a flag.

Top module: `szalu_core`

## Requirements
- R1: The opcode encoding is 000 add, 001 subtract, 010 AND, 011 OR, 100 XOR, 101 shift left, 110 shift right, 111 compare; add returns (a+b) reduced to the selected type.
- R2: Subtract returns (a-b) reduced to the selected type.
- R3: The size code is 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits. Every result bit above the size equals result bit size-1 when the sign input is 1, and equals 0 when it is 0.
- R4: Source bits above the selected size have no effect on the result or on any flag, for every opcode.
- R5: AND, OR and XOR return the bitwise operation reduced to the selected type.
- R6: Shift left moves the size-reduced first source left by the second source modulo the size in bits.
- R7: Shift right is arithmetic when the sign input is 1 and logical when it is 0. It works on the size-reduced first source, and its count is the second source modulo the size.
- R8: The flags eq, lt and gt compare the size-reduced sources for every opcode. Exactly one is set. The ordering is two's-complement when the sign input is 1 and unsigned otherwise.
- R9: The compare opcode returns a result with bit 0 = eq, bit 1 = lt, bit 2 = gt and all other bits zero.
- R10: Overflow wraps modulo 2^size before extension, including at 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code |
| src_a_i | input | 64 | First source operand |
| src_b_i | input | 64 | Second source operand (shift count for shifts) |
| sign_i | input | 1 | 1 selects the signed type, 0 the unsigned type |
| size_i | input | 2 | Operand size code |
| result_o | output | 64 | Type-normalised result |
| eq_o | output | 1 | Sources equal at the selected size |
| lt_o | output | 1 | First source below second |
| gt_o | output | 1 | First source above second |

## Verification
Source operands are given random, deliberately dirty upper bits. Each random case is repeated with those upper bits inverted. A design that reads past the size would then change its result or flip a compare flag.

Directed cases cover several boundaries:
- signed byte overflow from 0x7F to 0x80, which must come back fully sign-extended;
- unsigned wrap through zero, which must leave the upper bits clear;
- shift counts at or above the size, where a design that fails to take the modulus shifts everything out;
- signed right shifts of a negative byte, where a logical shift would insert zeros;
- compares where the signed and unsigned orderings disagree, which a design using the wrong ordering reports reversed.

// File: rtl/szalu_pkg.sv
package szalu_pkg;

    localparam int XLEN = 64;
    localparam int OPW  = 3;
    localparam int SZW  = 2;
    localparam int SHW  = $clog2(XLEN);

    typedef enum logic [OPW-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SHL = 3'd5,
        OP_SHR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef enum logic [SZW-1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } size_e;

    typedef struct packed {
        logic  sgn;
        size_e size;
    } dtype_t;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } flags_t;

    function automatic int bits_of(size_e s);
        return 8 << s;
    endfunction

    function automatic logic [XLEN-1:0] keep_mask(size_e s);
        return {XLEN{1'b1}} >> (XLEN - bits_of(s));
    endfunction

    function automatic logic [SHW-1:0] shift_amount(logic [SHW-1:0] raw, size_e s);
        logic [SHW-1:0] lim;
        lim = SHW'(bits_of(s) - 1);
        return raw & lim;
    endfunction

endpackage

// File: rtl/szalu_fit.sv
module szalu_fit
    import szalu_pkg::*;
(
    input  logic [XLEN-1:0] raw_i,
    input  dtype_t          dt_i,
    output logic [XLEN-1:0] fit_o
);

    logic [XLEN-1:0] keep;
    logic            fill;

    always_comb begin
        keep  = keep_mask(dt_i.size);
        fill  = dt_i.sgn & raw_i[bits_of(dt_i.size) - 1];
        fit_o = (raw_i & keep) | ({XLEN{fill}} & ~keep);
    end

endmodule

// File: rtl/szalu_shift.sv
module szalu_shift
    import szalu_pkg::*;
(
    input  logic [XLEN-1:0] val_i,
    input  logic [SHW-1:0]  amt_i,
    input  logic            right_i,
    input  logic            arith_i,
    output logic [XLEN-1:0] out_o
);

    always_comb begin
        if (!right_i)
            out_o = val_i << amt_i;
        else if (arith_i)
            out_o = $signed(val_i) >>> amt_i;
        else
            out_o = val_i >> amt_i;
    end

    always_comb begin
        if (!$isunknown({val_i, amt_i, right_i, arith_i})) begin
            a_r7_logical_fill: assert (!(right_i && !arith_i && amt_i != '0) || !out_o[XLEN-1])
                else $error("R7 logical right shift filled a one");
            a_r6_left_zero_in: assert (!(!right_i && amt_i != '0) || !out_o[0])
                else $error("R6 left shift did not insert zero");
        end
    end

endmodule

// File: rtl/szalu_cmp.sv
module szalu_cmp
    import szalu_pkg::*;
(
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sgn_i,
    output flags_t          flg_o
);

    always_comb begin
        flg_o.eq = (a_i == b_i);
        if (sgn_i) begin
            flg_o.lt = $signed(a_i) < $signed(b_i);
            flg_o.gt = $signed(a_i) > $signed(b_i);
        end else begin
            flg_o.lt = a_i < b_i;
            flg_o.gt = a_i > b_i;
        end
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, sgn_i})) begin
            a_r8_one_flag: assert ($onehot({flg_o.eq, flg_o.lt, flg_o.gt}))
                else $error("R8 flags not one-hot");
            a_r8_sign_order: assert (!(sgn_i && a_i[XLEN-1] != b_i[XLEN-1]) || (flg_o.lt == a_i[XLEN-1]))
                else $error("R8 signed ordering wrong for opposite signs");
        end
    end

endmodule

// File: rtl/szalu_core.sv
module szalu_core
    import szalu_pkg::*;
(
    input  logic [2:0]  op_i,
    input  logic [63:0] src_a_i,
    input  logic [63:0] src_b_i,
    input  logic        sign_i,
    input  logic [1:0]  size_i,
    output logic [63:0] result_o,
    output logic        eq_o,
    output logic        lt_o,
    output logic        gt_o
);

    localparam int NOPND = 2;

    dtype_t          dt;
    alu_op_e         op;
    logic [XLEN-1:0] opnd     [NOPND];
    logic [XLEN-1:0] opnd_fit [NOPND];
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] shifted;
    logic [SHW-1:0]  amt;
    flags_t          flg;

    assign dt      = '{sgn: sign_i, size: size_e'(size_i)};
    assign op      = alu_op_e'(op_i);
    assign opnd[0] = src_a_i;
    assign opnd[1] = src_b_i;

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        szalu_fit u_fit (
            .raw_i (opnd[g]),
            .dt_i  (dt),
            .fit_o (opnd_fit[g])
        );
    end

    assign amt = shift_amount(src_b_i[SHW-1:0], dt.size);

    szalu_shift u_shift (
        .val_i   (opnd_fit[0]),
        .amt_i   (amt),
        .right_i (op == OP_SHR),
        .arith_i (sign_i),
        .out_o   (shifted)
    );

    szalu_cmp u_cmp (
        .a_i   (opnd_fit[0]),
        .b_i   (opnd_fit[1]),
        .sgn_i (sign_i),
        .flg_o (flg)
    );

    always_comb begin
        unique case (op)
            OP_ADD:         raw = src_a_i + src_b_i;
            OP_SUB:         raw = src_a_i - src_b_i;
            OP_AND:         raw = src_a_i & src_b_i;
            OP_OR:          raw = src_a_i | src_b_i;
            OP_XOR:         raw = src_a_i ^ src_b_i;
            OP_SHL, OP_SHR: raw = shifted;
            default:        raw = {{(XLEN-3){1'b0}}, flg};
        endcase
    end

    szalu_fit u_fit_res (
        .raw_i (raw),
        .dt_i  (dt),
        .fit_o (result_o)
    );

    assign eq_o = flg.eq;
    assign lt_o = flg.lt;
    assign gt_o = flg.gt;

    logic [XLEN-1:0] upper_chk;
    logic            top_bit;
    always_comb begin
        case (size_i)
            2'd0:    begin upper_chk = {8'h00,  result_o[63:8]};  top_bit = result_o[7];  end
            2'd1:    begin upper_chk = {16'h0,  result_o[63:16]}; top_bit = result_o[15]; end
            2'd2:    begin upper_chk = {32'h0,  result_o[63:32]}; top_bit = result_o[31]; end
            default: begin upper_chk = '0;                        top_bit = 1'b0;         end
        endcase
        if (!$isunknown({op_i, src_a_i, src_b_i, sign_i, size_i})) begin
            a_r3_upper_clean: assert (size_i == 2'd3 ||
                upper_chk == ((sign_i && top_bit) ? ({XLEN{1'b1}} >> (8 << size_i)) : '0))
                else $error("R3 upper bits are not a clean extension");
            a_r9_cmp_high_zero: assert (op_i != 3'd7 || result_o[63:3] == '0)
                else $error("R9 compare result has stray high bits");
        end
    end

endmodule

// File: tb/sim_szalu_core.sv
module sim_szalu_core;

    logic        clk = 1'b0;
    logic [2:0]  op;
    logic [63:0] a, b;
    logic        sg;
    logic [1:0]  sz;
    logic [63:0] res;
    logic        eq, lt, gt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    szalu_core u0 (
        .op_i(op), .src_a_i(a), .src_b_i(b), .sign_i(sg), .size_i(sz),
        .result_o(res), .eq_o(eq), .lt_o(lt), .gt_o(gt)
    );

    function automatic logic [63:0] ext(logic [63:0] v, logic s, logic [1:0] z);
        int k = 64 - (8 << z);
        logic [63:0] up = v << k;
        if (s) return $signed(up) >>> k;
        return up >> k;
    endfunction

    function automatic logic [2:0] ref_flags(logic [63:0] x0, logic [63:0] y0, logic s, logic [1:0] z);
        logic [63:0] x = ext(x0, s, z);
        logic [63:0] y = ext(y0, s, z);
        if (s) begin x[63] = ~x[63]; y[63] = ~y[63]; end
        return {x > y, x < y, x == y};
    endfunction

    function automatic logic [63:0] ref_res(logic [2:0] o, logic [63:0] x, logic [63:0] y,
                                            logic s, logic [1:0] z);
        int w = 8 << z;
        int n = int'(y[5:0]) % w;
        case (o)
            3'd0: return ext(x + y, s, z);
            3'd1: return ext(x - y, s, z);
            3'd2: return ext(x & y, s, z);
            3'd3: return ext(x | y, s, z);
            3'd4: return ext(x ^ y, s, z);
            3'd5: return ext(ext(x, s, z) << n, s, z);
            3'd6: return s ? ext($signed(ext(x, s, z)) >>> n, s, z) : ext(ext(x, s, z) >> n, s, z);
            default: return {61'b0, ref_flags(x, y, s, z)};
        endcase
    endfunction

    task automatic drive(logic [2:0] o, logic [63:0] x, logic [63:0] y, logic s, logic [1:0] z);
        @(posedge clk);
        op = o; a = x; b = y; sg = s; sz = z;
        @(negedge clk);
    endtask

    task automatic cmp64(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d sg=%0d sz=%0d a=%h b=%h actual=%h expected=%h",
                     tag, op, sg, sz, a, b, act, exp);
        end
    endtask

    task automatic run_model(string tag, logic [2:0] o, logic [63:0] x, logic [63:0] y,
                             logic s, logic [1:0] z);
        drive(o, x, y, s, z);
        cmp64(tag, res, ref_res(o, x, y, s, z));
        cmp64({tag, "/R8 flags"}, {61'b0, gt, lt, eq}, {61'b0, ref_flags(x, y, s, z)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] r0, f0, dirty;
        void'($urandom(32'h5eed_0042));
        op = 3'd0; a = '0; b = '0; sg = 1'b0; sz = 2'd0;
        @(negedge clk);
        cmp64("R1 idle zero result", res, 64'h0);
        cmp64("R8 idle eq", {61'b0, gt, lt, eq}, 64'h1);

        drive(3'd0, 64'h7F, 64'h01, 1'b1, 2'd0);
        cmp64("R1/R3 signed byte overflow", res, 64'hFFFF_FFFF_FFFF_FF80);
        drive(3'd0, 64'hAB00_00FF, 64'h1, 1'b0, 2'd0);
        cmp64("R10 unsigned byte wrap", res, 64'h0);
        drive(3'd1, 64'h0, 64'h1, 1'b1, 2'd1);
        cmp64("R2 signed half 0-1", res, 64'hFFFF_FFFF_FFFF_FFFF);
        drive(3'd1, 64'h0, 64'h1, 1'b0, 2'd2);
        cmp64("R2/R3 unsigned word 0-1", res, 64'h0000_0000_FFFF_FFFF);
        drive(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 1'b0, 2'd3);
        cmp64("R10 doubleword wrap", res, 64'h1);
        drive(3'd5, 64'h1234_0001, 64'd17, 1'b0, 2'd1);
        cmp64("R6 half shl count mod 16", res, 64'h2);
        drive(3'd6, 64'h55AA_0080, 64'd9, 1'b1, 2'd0);
        cmp64("R7 signed byte shr arith", res, 64'hFFFF_FFFF_FFFF_FFC0);
        drive(3'd6, 64'h55AA_0080, 64'd9, 1'b0, 2'd0);
        cmp64("R7 unsigned byte shr logical", res, 64'h40);
        drive(3'd7, 64'hFFFF_0080, 64'h7700_0001, 1'b1, 2'd0);
        cmp64("R9 signed byte compare lt", res, 64'h2);
        drive(3'd7, 64'hFFFF_0080, 64'h7700_0001, 1'b0, 2'd0);
        cmp64("R9 unsigned byte compare gt", res, 64'h4);
        drive(3'd2, 64'hFF00_F0F0, 64'h00FF_FF0F, 1'b1, 2'd1);
        cmp64("R5 signed half and", res, 64'hFFFF_FFFF_FFFF_F000);
        drive(3'd4, 64'hDEAD_0000_1234_5678, 64'h0, 1'b0, 2'd2);
        cmp64("R4/R5 word xor drops dirty upper", res, 64'h1234_5678);

        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  o = 3'($urandom);
            logic        s = 1'($urandom);
            logic [1:0]  z = 2'($urandom);
            logic [63:0] x = {$urandom, $urandom};
            logic [63:0] y = {$urandom, $urandom};
            if (i % 7 == 0) y = x ^ 64'hFFFF_FFFF_FFFF_FF00;
            run_model("R1-model R3 random", o, x, y, s, z);
            if (z != 2'd3) begin
                r0 = res;
                f0 = {61'b0, gt, lt, eq};
                dirty = ~({64{1'b1}} >> (64 - (8 << z)));
                drive(o, x ^ dirty, y ^ (o >= 3'd5 ? 64'h0 : dirty), s, z);
                cmp64("R4 dirty upper result", res, r0);
                cmp64("R4 dirty upper flags", {61'b0, gt, lt, eq}, f0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule